// File: doc/BRIEF.md
# Serial Port Peripheral on a Register Bus

This block is a byte-wide asynchronous serial port that a small processor controls through a 16-bit register bus. The frame is fixed: one low start bit, eight data bits sent least significant bit first, and one high stop bit. A single programmable divisor sets how many clock cycles each bit lasts, and both directions use it.

Software starts a transmission by writing a byte to the transmit register. It polls the transmit-idle flag, or takes an interrupt, to learn when the line is free again. Received bytes land in a holding register that has a valid flag and a separate bad-frame flag. Reading the byte clears the valid flag. An event unit records the rising edges of the receive-valid and transmit-idle flags as pending bits. Software clears those bits by writing ones to them. The unit drives one interrupt line from the pending bits that are enabled.

Every register sits at its own word address. Read data is registered and appears on the bus in the cycle after the read strobe.

Top module: `uart_csr_top`

## Requirements
- R1: After reset the divisor reads 16, receive-valid, bad-frame, pending and enable all read 0, transmit-idle reads 1, the tx line is high and irq is low.
- R2: Offset 0 holds the divisor, which is readable and writable. Each bit on tx and rx lasts that many clock cycles (values of 2 and above).
- R3: Writing offset 4 while the transmitter is idle sends a frame on tx. The frame is a low start bit, then wdata[7:0] LSB first, then a high stop bit, with each bit held for one divisor period.
- R4: Offset 5 reads 1 when the transmitter is idle. It reads 0 for exactly ten bit periods after a frame starts. A write to offset 4 while the transmitter is busy is ignored.
- R5: A well-formed received frame puts its byte in bits [7:0] of offset 1, with bits [15:8] zero, and sets the receive-valid flag, which reads as bit 0 of offset 2.
- R6: A read of offset 1 clears the receive-valid flag.
- R7: A frame whose stop bit is sampled low sets the bad-frame flag, bit 0 of offset 3. It leaves the received byte and the receive-valid flag unchanged. The next well-formed frame clears the flag.
- R8: Offset 8 reads the live flags: bit 0 is receive-valid and bit 1 is transmit-idle.
- R9: Offset 9 holds the pending bits. Bit 0 is set when receive-valid rises and bit 1 when transmit-idle rises. Writing 1 to a bit clears it, and a set on the same cycle wins. Offset 10 is a readable and writable 2-bit enable mask.
- R10: irq is high exactly when some pending bit has its enable bit set.
- R11: The rdata output presents the addressed register in the cycle after the read strobe. Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 5 | Register word address |
| csr_wdata | input | 16 | Write data |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_rdata | output | 16 | Registered read data |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
The transmitter is checked on the bytes 0xA5 and 0x3C by sampling every bit at its midpoint. A byte with alternating halves and a byte with clustered bits separate a bit-order error from an off-by-one period error. The receiver is tested with a good frame, a frame with a low stop bit and then another good frame, and a frame sent at a different divisor. Together these show whether data, valid and error update independently and whether the divisor reaches the receive side. A write to the transmit register while a frame is in flight shows whether busy writes are dropped or restart the frame. Interrupt checks toggle the enable and pending bits to tell masking apart from clearing.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
    localparam int CSR_DW = 16;
    localparam int CSR_AW = 5;

    typedef logic [CSR_AW-1:0] csr_addr_t;
    typedef logic [CSR_DW-1:0] csr_word_t;

    localparam csr_addr_t OFS_DIV    = 5'd0;
    localparam csr_addr_t OFS_RXDATA = 5'd1;
    localparam csr_addr_t OFS_RXRDY  = 5'd2;
    localparam csr_addr_t OFS_RXERR  = 5'd3;
    localparam csr_addr_t OFS_TXDATA = 5'd4;
    localparam csr_addr_t OFS_TXRDY  = 5'd5;
    localparam csr_addr_t OFS_EVSTAT = 5'd8;
    localparam csr_addr_t OFS_EVPEND = 5'd9;
    localparam csr_addr_t OFS_EVEN   = 5'd10;

    localparam int NUM_EV = 2;

    // Event vector: bit 0 receive-valid, bit 1 transmit-idle.
    typedef struct packed {
        logic tx_idle;
        logic rx_valid;
    } ev_vec_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic is_readable(csr_addr_t a);
        return (a == OFS_DIV) || (a == OFS_RXDATA) || (a == OFS_RXRDY) ||
               (a == OFS_RXERR) || (a == OFS_TXRDY) || (a == OFS_EVSTAT) ||
               (a == OFS_EVPEND) || (a == OFS_EVEN);
    endfunction
endpackage

// File: rtl/uart_csr_tx.sv
module uart_csr_tx #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              tx_o,
    output logic              idle
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int LEFT_W  = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shift_q;
    logic [DIV_W-1:0]   cnt_q;
    logic [LEFT_W-1:0]  left_q;
    logic               busy_q;
    logic               line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '1;
            cnt_q   <= '0;
            left_q  <= '0;
            busy_q  <= 1'b0;
            line_q  <= 1'b1;
        end else if (!busy_q) begin
            if (start) begin
                shift_q <= {1'b1, data, 1'b0};
                line_q  <= 1'b0;
                busy_q  <= 1'b1;
                cnt_q   <= div - 1'b1;
                left_q  <= LEFT_W'(FRAME_W - 1);
            end
        end else if (cnt_q == '0) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
                line_q <= 1'b1;
            end else begin
                shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                line_q  <= shift_q[1];
                cnt_q   <= div - 1'b1;
                left_q  <= left_q - 1'b1;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tx_o = line_q;
    assign idle = !busy_q;
endmodule

// File: rtl/uart_csr_rx.sv
module uart_csr_rx
    import uart_csr_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              rx_i,
    output logic              done,
    output logic              frame_err,
    output logic [DATA_W-1:0] data
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [1:0]        sync_q;
    logic              prev_q;
    rx_state_e         state_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              line;

    assign line = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 2'b11;
            prev_q    <= 1'b1;
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            shift_q   <= '0;
            done      <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            sync_q    <= {sync_q[0], rx_i};
            prev_q    <= line;
            done      <= 1'b0;
            frame_err <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (prev_q && !line) begin
                        state_q <= RX_START;
                        cnt_q   <= (div >> 1) - 1'b1;
                    end
                end
                RX_START: begin
                    if (cnt_q == '0) begin
                        if (!line) begin
                            state_q <= RX_DATA;
                            cnt_q   <= div - 1'b1;
                            idx_q   <= '0;
                        end else begin
                            state_q <= RX_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == '0) begin
                        shift_q <= {line, shift_q[DATA_W-1:1]};
                        cnt_q   <= div - 1'b1;
                        if (idx_q == IDX_W'(DATA_W - 1)) state_q <= RX_STOP;
                        else idx_q <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == '0) begin
                        if (line) done <= 1'b1;
                        else frame_err <= 1'b1;
                        state_q <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign data = shift_q;
endmodule

// File: rtl/uart_csr_events.sv
module uart_csr_events #(
    parameter int         N          = 2,
    parameter logic [1:0] RESET_PREV = 2'b10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] pending,
    output logic [N-1:0] enable,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_ev
        logic prev_q;
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= RESET_PREV[i];
                pend_q <= 1'b0;
            end else begin
                prev_q <= src[i];
                if (src[i] && !prev_q) pend_q <= 1'b1;
                else if (clr_we && wdata[i]) pend_q <= 1'b0;
            end
        end
        assign pending[i] = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) enable <= '0;
        else if (en_we) enable <= wdata;
    end

    assign irq = |(pending & enable);
endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
    import uart_csr_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DATA_W    = 8,
    parameter int DIV_RESET = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  csr_addr,
    input  logic [15:0] csr_wdata,
    input  logic        csr_we,
    input  logic        csr_re,
    output logic [15:0] csr_rdata,
    input  logic        rx_i,
    output logic        tx_o,
    output logic        irq_o
);
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rx_data_q;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_rdy_q;
    logic              rx_err_q;
    logic              rx_done;
    logic              rx_ferr;
    logic              tx_idle;
    logic              tx_start;
    ev_vec_t           ev_src;
    logic [NUM_EV-1:0] ev_pend;
    logic [NUM_EV-1:0] ev_en;
    csr_word_t         rd_mux;

    wire wr_div  = csr_we && (csr_addr == OFS_DIV);
    wire wr_tx   = csr_we && (csr_addr == OFS_TXDATA);
    wire wr_pend = csr_we && (csr_addr == OFS_EVPEND);
    wire wr_en   = csr_we && (csr_addr == OFS_EVEN);
    wire rd_data = csr_re && (csr_addr == OFS_RXDATA);

    assign tx_start = wr_tx && tx_idle;

    uart_csr_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst(rst), .div(div_q), .start(tx_start),
        .data(csr_wdata[DATA_W-1:0]), .tx_o(tx_o), .idle(tx_idle)
    );

    uart_csr_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) rx_u (
        .clk(clk), .rst(rst), .div(div_q), .rx_i(rx_i),
        .done(rx_done), .frame_err(rx_ferr), .data(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= DIV_W'(DIV_RESET);
            rx_data_q <= '0;
            rx_rdy_q  <= 1'b0;
            rx_err_q  <= 1'b0;
        end else begin
            if (wr_div) div_q <= csr_wdata[DIV_W-1:0];
            if (rx_done) begin
                rx_data_q <= rx_byte;
                rx_rdy_q  <= 1'b1;
                rx_err_q  <= 1'b0;
            end else begin
                if (rd_data) rx_rdy_q <= 1'b0;
                if (rx_ferr) rx_err_q <= 1'b1;
            end
        end
    end

    assign ev_src = '{tx_idle: tx_idle, rx_valid: rx_rdy_q};

    uart_csr_events #(.N(NUM_EV), .RESET_PREV(2'b10)) ev_i (
        .clk(clk), .rst(rst), .src(ev_src), .clr_we(wr_pend), .en_we(wr_en),
        .wdata(csr_wdata[NUM_EV-1:0]), .pending(ev_pend), .enable(ev_en),
        .irq(irq_o)
    );

    always_comb begin
        rd_mux = '0;
        unique case (csr_addr)
            OFS_DIV:    rd_mux = CSR_DW'(div_q);
            OFS_RXDATA: rd_mux = CSR_DW'(rx_data_q);
            OFS_RXRDY:  rd_mux = CSR_DW'(rx_rdy_q);
            OFS_RXERR:  rd_mux = CSR_DW'(rx_err_q);
            OFS_TXRDY:  rd_mux = CSR_DW'(tx_idle);
            OFS_EVSTAT: rd_mux = CSR_DW'(ev_src);
            OFS_EVPEND: rd_mux = CSR_DW'(ev_pend);
            OFS_EVEN:   rd_mux = CSR_DW'(ev_en);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) csr_rdata <= '0;
        else if (csr_re) csr_rdata <= rd_mux;
    end
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
    import uart_csr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [4:0]  csr_addr,
    input logic [15:0] csr_wdata,
    input logic        csr_we,
    input logic        csr_re,
    input logic [15:0] csr_rdata,
    input logic        tx_o,
    input logic        irq_o,
    input logic        rx_rdy,
    input logic        tx_idle,
    input logic        rx_done
);
    logic [1:0] en_shadow;

    always_ff @(posedge clk) begin
        if (rst) en_shadow <= '0;
        else if (csr_we && csr_addr == OFS_EVEN) en_shadow <= csr_wdata[1:0];
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (tx_o && !irq_o && tx_idle && !rx_rdy));

    // R3
    a_r3_start_bit: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == OFS_TXDATA && tx_idle) |=> (!tx_o && !tx_idle));

    // R3
    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> tx_o);

    // R4
    a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == OFS_TXDATA && !tx_idle) |=> $stable(tx_o) || !tx_idle);

    // R6
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (csr_re && csr_addr == OFS_RXDATA && !rx_done) |=> !rx_rdy);

    // R10
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (en_shadow != 2'b00));

    // R11
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_re && !is_readable(csr_addr)) |=> (csr_rdata == 16'h0000));
endmodule

bind uart_csr_top uart_csr_chk chk_i (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_re(csr_re), .csr_rdata(csr_rdata), .tx_o(tx_o),
    .irq_o(irq_o), .rx_rdy(rx_rdy_q), .tx_idle(tx_idle), .rx_done(rx_done)
);

// File: tb/uart_csr_top_tb_top.sv
`timescale 1ns/1ps
module uart_csr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  csr_addr = '0;
    logic [15:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic        csr_re = 1'b0;
    logic [15:0] csr_rdata;
    logic        rx_i = 1'b1;
    logic        tx_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        string     tag;
        logic [4:0] addr;
        logic [15:0] exp;
    } rd_item_t;
    rd_item_t sb_q[$];
    logic re_q = 1'b0;

    always #5 clk = ~clk;

    uart_csr_top dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_re(csr_re), .csr_rdata(csr_rdata),
        .rx_i(rx_i), .tx_o(tx_o), .irq_o(irq_o)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected read per completed read strobe.
    always @(posedge clk) re_q <= csr_re;
    always @(negedge clk) begin
        if (re_q) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 16'h1, 16'h0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check($sformatf("%s addr %0d", it.tag, it.addr), csr_rdata, it.exp);
            end
        end
    end

    task automatic csr_write(logic [4:0] a, logic [15:0] d);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(logic [4:0] a, logic [15:0] exp, string tag);
        rd_item_t it;
        it.tag = tag; it.addr = a; it.exp = exp;
        sb_q.push_back(it);
        csr_addr = a; csr_re = 1'b1;
        @(negedge clk);
        csr_re = 1'b0;
    endtask

    task automatic send_rx(logic [7:0] b, logic stop, int bitlen);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rx_i = fr[i];
            repeat (bitlen) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (2 * bitlen) @(negedge clk);
    endtask

    task automatic check_tx_frame(logic [7:0] b, int bitlen, string tag);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            repeat (bitlen / 2) @(negedge clk);
            check($sformatf("%s bit %0d", tag, i), {15'd0, tx_o}, {15'd0, fr[i]});
            repeat (bitlen - bitlen / 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 tx idle high", {15'd0, tx_o}, 16'h1);
        check("R1 irq low", {15'd0, irq_o}, 16'h0);
        csr_read(5'd0, 16'd16, "R1 divisor");
        csr_read(5'd2, 16'h0, "R1 rx valid");
        csr_read(5'd3, 16'h0, "R1 bad frame");
        csr_read(5'd5, 16'h1, "R1 tx idle");
        csr_read(5'd9, 16'h0, "R1 pending");
        csr_read(5'd10, 16'h0, "R1 enable");
        csr_read(5'd8, 16'h2, "R8 status after reset");

        // R2 divisor write/read
        csr_write(5'd0, 16'd8);
        csr_read(5'd0, 16'd8, "R2 divisor readback");

        // R3 transmit frame bits
        csr_write(5'd4, 16'h00A5);
        check_tx_frame(8'hA5, 8, "R3 frame A5");
        repeat (2) @(negedge clk);
        csr_read(5'd9, 16'h2, "R9 tx pending");
        csr_read(5'd8, 16'h2, "R8 status tx idle");
        csr_write(5'd9, 16'h3);
        csr_read(5'd9, 16'h0, "R9 write-one clear");

        // R4 busy flag and ignored busy write
        csr_write(5'd4, 16'h003C);
        csr_read(5'd5, 16'h0, "R4 busy flag");
        csr_write(5'd4, 16'h00FF);
        repeat (78) @(negedge clk);
        check("R4 line idle after frame", {15'd0, tx_o}, 16'h1);
        csr_read(5'd5, 16'h1, "R4 idle after ten bits");
        repeat (2) @(negedge clk);
        check("R4 no restarted frame", {15'd0, tx_o}, 16'h1);
        csr_write(5'd9, 16'h3);

        // R3 second pattern checked bitwise
        csr_write(5'd4, 16'h013C);
        check_tx_frame(8'h3C, 8, "R3 frame 3C");
        repeat (2) @(negedge clk);
        csr_write(5'd9, 16'h3);

        // R9 enable register, R10 irq
        csr_write(5'd10, 16'h1);
        csr_read(5'd10, 16'h1, "R9 enable readback");
        check("R10 irq low with nothing pending", {15'd0, irq_o}, 16'h0);

        // R5 good receive
        send_rx(8'h5A, 1'b1, 8);
        csr_read(5'd2, 16'h1, "R5 rx valid");
        check("R10 irq on rx event", {15'd0, irq_o}, 16'h1);
        csr_read(5'd8, 16'h3, "R8 status both");
        csr_read(5'd1, 16'h005A, "R5 rx data");
        csr_read(5'd2, 16'h0, "R6 valid cleared by read");
        csr_read(5'd3, 16'h0, "R7 no bad frame");
        csr_read(5'd9, 16'h1, "R9 rx pending");
        csr_write(5'd10, 16'h2);
        check("R10 irq masked", {15'd0, irq_o}, 16'h0);
        csr_write(5'd10, 16'h1);
        check("R10 irq unmasked", {15'd0, irq_o}, 16'h1);
        csr_write(5'd9, 16'h1);
        check("R10 irq after clear", {15'd0, irq_o}, 16'h0);

        // R7 framing error
        send_rx(8'h33, 1'b0, 8);
        csr_read(5'd3, 16'h1, "R7 bad frame set");
        csr_read(5'd2, 16'h0, "R7 valid unchanged");
        csr_read(5'd1, 16'h005A, "R7 data unchanged");
        send_rx(8'hC3, 1'b1, 8);
        csr_read(5'd3, 16'h0, "R7 bad frame cleared");
        csr_read(5'd1, 16'h00C3, "R7 next byte");

        // R2 divisor reaches receiver
        csr_write(5'd0, 16'd12);
        send_rx(8'h96, 1'b1, 12);
        csr_read(5'd1, 16'h0096, "R2 rx at divisor 12");

        // R11 unmapped
        csr_write(5'd7, 16'hFFFF);
        csr_read(5'd7, 16'h0, "R11 unmapped 7");
        csr_read(5'd15, 16'h0, "R11 unmapped 15");
        csr_read(5'd31, 16'h0, "R11 unmapped 31");
        csr_read(5'd0, 16'd12, "R11 divisor untouched");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) check("scoreboard leftover", 16'(sb_q.size()), 16'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule